// File: doc/BRIEF.md
# Triple-Replica Scan Compare Unit

This block watches three redundant copies of the same logic. Each copy has its own scan chain. A chain samples the copy's internal and output nodes, which include flip-flop inputs and outputs as well as module and voter outputs. A chain cell has only a capture/shift stage and no hold latch, so the watched paths are never delayed.

A capture pulse loads all three chains on the same rising edge of the system clock. The chains then shift together, one position per enabled cycle. The three bits that leave the chains in a given cycle are voted 2-of-3 at once and then dropped, so no shifted data is stored. From these votes the block builds a diagnosis:
- whether any copy disagreed,
- which copy was the odd one out,
- where the first disagreement was,
- whether a disagreement fell in the leading controller region of the chain,
- whether the disagreements form a pattern that cannot be traced to one copy.

A supervising controller reads the diagnosis when the scan-done pulse arrives and decides what to repair.

The sequencer has three states:
- **IDLE**: no scan is running.
- **SHIFT**: positions are being consumed.
- **DONE**: a one-cycle state that raises `scan_done`.

The sequencer has these transitions:
- *capture* moves from any state into SHIFT.
- *last-step* moves from SHIFT to DONE after the final position.
- *retire* moves from DONE back to IDLE.

Top module: `tmr_scan_cmp`

## Requirements
- R1: After reset `busy`, `scan_done`, `flt_any`, `flt_odd`, `flt_pos`, `flt_ctrl` and `flt_multi` are all zero.
- R2: A high `capture` at a rising edge loads all three chains from the taps, clears the diagnosis and enters SHIFT (`busy`=1) from any state. A capture during a running scan restarts that scan.
- R3: In SHIFT, each rising edge with `shift` high consumes one position, and tap index k is compared at the k-th step. An edge with `shift` low consumes nothing.
- R4: `scan_done` is high for exactly one cycle. It starts right after the edge that consumes position CHAIN_LEN-1, so with `shift` held high it arrives CHAIN_LEN cycles after the capture edge. The block then returns to IDLE.
- R5: If `capture` and `shift` are both high on one edge, the capture wins and no position is consumed at that edge.
- R6: When the disagreements come from one copy at non-adjacent positions, `flt_odd` names that copy and `flt_pos` holds the first mismatching index. The codes are 1 for tap A, 2 for tap B and 3 for tap C.
- R7: With identical taps, `flt_any`=0 and `flt_odd`=0 when the scan completes.
- R8: `flt_multi` is set if two adjacent positions both mismatch, or if a later mismatch names a different copy than the first one. While it is set, `flt_odd` reads 0 and `flt_pos` still holds the first mismatch.
- R9: `flt_ctrl` is set when any mismatch lies at an index below CTRL_LEN.
- R10: In IDLE and DONE, `shift` has no effect, and the diagnosis outputs stay unchanged until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; capture and shift act on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| capture | input | 1 | Load all chains from the taps and start a scan |
| shift | input | 1 | Advance the chains one position |
| taps_a | input | CHAIN_LEN | Observed nodes of copy A |
| taps_b | input | CHAIN_LEN | Observed nodes of copy B |
| taps_c | input | CHAIN_LEN | Observed nodes of copy C |
| busy | output | 1 | A scan is in progress |
| scan_done | output | 1 | One-cycle pulse after the final position |
| flt_any | output | 1 | At least one mismatch was seen |
| flt_odd | output | 2 | Odd copy: 0 none or multi, 1 A, 2 B, 3 C |
| flt_pos | output | clog2(CHAIN_LEN) | Index of the first mismatch |
| flt_ctrl | output | 1 | A mismatch fell in the controller region |
| flt_multi | output | 1 | The mismatch pattern cannot be tied to one copy |

## Verification
Capture and shift can both be high on the same rising edge. In that cycle the sequencer must load and not advance. The bench holds `shift` high through every capture, both from IDLE and in the middle of a running scan. It then judges the result by counting the cycles to `scan_done`, which must equal exactly CHAIN_LEN plus any paused cycles. It also checks that the diagnosis of the new taps starts from index 0, with nothing carried over from the aborted scan.

// File: rtl/tmr_scan_pkg.sv
package tmr_scan_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_DONE  = 2'd2
    } scan_state_t;

    // Odd-one-out code of three bits: 0 agree, 1 first, 2 second, 3 third
    function automatic logic [1:0] odd_of(input logic a, input logic b, input logic c);
        if (a == b && b == c) return 2'd0;
        else if (b == c)      return 2'd1;
        else if (a == c)      return 2'd2;
        else                  return 2'd3;
    endfunction

endpackage

// File: rtl/tmr_scan_chain.sv
module tmr_scan_chain #(
    parameter int CHAIN_LEN = 100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 adv,
    input  logic [CHAIN_LEN-1:0] taps,
    output logic                 sout
);
    logic [CHAIN_LEN-1:0] cells;

    // Capture/shift stage only: the observed taps are never retimed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cells <= '0;
        else if (load) cells <= taps;
        else if (adv)  cells <= {1'b0, cells[CHAIN_LEN-1:1]};
    end

    assign sout = cells[0];
endmodule

// File: rtl/tmr_scan_seq.sv
module tmr_scan_seq
    import tmr_scan_pkg::*;
#(
    parameter int CHAIN_LEN = 100,
    localparam int PW = $clog2(CHAIN_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          shift,
    output logic          load,
    output logic          step,
    output logic [PW-1:0] pos,
    output logic          busy,
    output logic          done
);
    localparam logic [PW-1:0] LAST = PW'(CHAIN_LEN - 1);

    scan_state_t state, nstate;
    logic        last_step;

    assign last_step = step && (pos == LAST);

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:  if (capture) nstate = S_SHIFT;
            S_SHIFT: if (capture) nstate = S_SHIFT;
                     else if (last_step) nstate = S_DONE;
            S_DONE:  nstate = capture ? S_SHIFT : S_IDLE;
            default: nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            pos   <= '0;
        end else begin
            state <= nstate;
            if (capture)   pos <= '0;
            else if (step) pos <= pos + 1'b1;
        end
    end

    always_comb begin
        load = capture;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_SHIFT: begin
                busy = 1'b1;
                step = shift && !capture;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tmr_scan_diag.sv
module tmr_scan_diag
    import tmr_scan_pkg::*;
#(
    parameter int CHAIN_LEN = 100,
    parameter int CTRL_LEN  = 8,
    localparam int PW = $clog2(CHAIN_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [PW-1:0] pos,
    input  logic          bit_a,
    input  logic          bit_b,
    input  logic          bit_c,
    output logic          found,
    output logic [1:0]    first_odd,
    output logic [PW-1:0] first_pos,
    output logic          ctrl_hit,
    output logic          multi
);
    logic [1:0] odd_now;
    logic       mis_now;
    logic       prev_mis;
    logic       in_ctrl;

    assign odd_now = odd_of(bit_a, bit_b, bit_c);
    assign mis_now = (odd_now != 2'd0);
    assign in_ctrl = (int'(pos) < CTRL_LEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            found     <= 1'b0;
            first_odd <= 2'd0;
            first_pos <= '0;
            ctrl_hit  <= 1'b0;
            multi     <= 1'b0;
            prev_mis  <= 1'b0;
        end else if (clear) begin
            found     <= 1'b0;
            first_odd <= 2'd0;
            first_pos <= '0;
            ctrl_hit  <= 1'b0;
            multi     <= 1'b0;
            prev_mis  <= 1'b0;
        end else if (step) begin
            prev_mis <= mis_now;
            if (mis_now) begin
                if (!found) begin
                    found     <= 1'b1;
                    first_odd <= odd_now;
                    first_pos <= pos;
                end else if (odd_now != first_odd) begin
                    multi <= 1'b1;
                end
                if (prev_mis) multi    <= 1'b1;
                if (in_ctrl)  ctrl_hit <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_scan_cmp.sv
module tmr_scan_cmp #(
    parameter int CHAIN_LEN = 100,
    parameter int CTRL_LEN  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         capture,
    input  logic                         shift,
    input  logic [CHAIN_LEN-1:0]         taps_a,
    input  logic [CHAIN_LEN-1:0]         taps_b,
    input  logic [CHAIN_LEN-1:0]         taps_c,
    output logic                         busy,
    output logic                         scan_done,
    output logic                         flt_any,
    output logic [1:0]                   flt_odd,
    output logic [$clog2(CHAIN_LEN)-1:0] flt_pos,
    output logic                         flt_ctrl,
    output logic                         flt_multi
);
    localparam int PW = $clog2(CHAIN_LEN);
    localparam int NREP = 3;

    logic [NREP-1:0][CHAIN_LEN-1:0] taps_all;
    logic [NREP-1:0]                sout;
    logic                           load, step;
    logic [PW-1:0]                  pos;
    logic [1:0]                     first_odd;
    logic                           multi;

    assign taps_all = {taps_c, taps_b, taps_a};

    tmr_scan_seq #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift),
        .load(load), .step(step), .pos(pos), .busy(busy), .done(scan_done)
    );

    for (genvar g = 0; g < NREP; g++) begin : g_chain
        tmr_scan_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
            .clk(clk), .rst_n(rst_n), .load(load), .adv(step),
            .taps(taps_all[g]), .sout(sout[g])
        );
    end

    tmr_scan_diag #(.CHAIN_LEN(CHAIN_LEN), .CTRL_LEN(CTRL_LEN)) u_diag (
        .clk(clk), .rst_n(rst_n), .clear(load), .step(step), .pos(pos),
        .bit_a(sout[0]), .bit_b(sout[1]), .bit_c(sout[2]),
        .found(flt_any), .first_odd(first_odd), .first_pos(flt_pos),
        .ctrl_hit(flt_ctrl), .multi(multi)
    );

    assign flt_multi = multi;
    assign flt_odd   = multi ? 2'd0 : first_odd;
endmodule

// File: rtl/tmr_scan_cmp_chk.sv
module tmr_scan_cmp_chk #(
    parameter int PW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          capture,
    input logic          busy,
    input logic          scan_done,
    input logic          flt_any,
    input logic [1:0]    flt_odd,
    input logic [PW-1:0] flt_pos,
    input logic          flt_multi
);
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    // R4
    done_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_done) |-> $past(busy));

    // R2
    capture_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (busy && !flt_any && !flt_multi && !scan_done));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !busy) |=> ($stable(flt_any) && $stable(flt_odd) && $stable(flt_pos)));

    // R6
    first_pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_any && !capture) |=> $stable(flt_pos));

    // R8
    multi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_multi && !capture) |=> flt_multi);
endmodule

bind tmr_scan_cmp tmr_scan_cmp_chk #(.PW($clog2(CHAIN_LEN))) u_chk (
    .clk(clk), .rst_n(rst_n), .capture(capture), .busy(busy),
    .scan_done(scan_done), .flt_any(flt_any), .flt_odd(flt_odd),
    .flt_pos(flt_pos), .flt_multi(flt_multi)
);

// File: tb/sim_tmr_scan_cmp.sv
`timescale 1ns/1ps
module sim_tmr_scan_cmp;
    localparam int LEN  = 100;
    localparam int CTRL = 8;
    localparam int PW   = $clog2(LEN);

    typedef struct packed {
        logic          any;
        logic [1:0]    odd;
        logic [PW-1:0] pos;
        logic          ctrl;
        logic          multi;
    } exp_t;

    logic clk = 0, rst_n = 0, capture = 0, shift = 0;
    logic [LEN-1:0] ta = '0, tb = '0, tc = '0;
    logic busy, scan_done, flt_any, flt_ctrl, flt_multi;
    logic [1:0] flt_odd;
    logic [PW-1:0] flt_pos;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    tmr_scan_cmp #(.CHAIN_LEN(LEN), .CTRL_LEN(CTRL)) u0 (
        .clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift),
        .taps_a(ta), .taps_b(tb), .taps_c(tc), .busy(busy), .scan_done(scan_done),
        .flt_any(flt_any), .flt_odd(flt_odd), .flt_pos(flt_pos),
        .flt_ctrl(flt_ctrl), .flt_multi(flt_multi)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected diagnosis from the requirement text (R6..R9)
    function automatic exp_t model(input logic [LEN-1:0] a, b, c);
        exp_t e = '0;
        logic prev = 0;
        logic [1:0] fo = 0;
        for (int k = 0; k < LEN; k++) begin
            logic m;
            logic [1:0] o;
            m = !(a[k] == b[k] && b[k] == c[k]);
            o = (b[k] == c[k]) ? 2'd1 : (a[k] == c[k]) ? 2'd2 : 2'd3;
            if (m) begin
                if (!e.any) begin e.any = 1; fo = o; e.pos = PW'(k); end
                else if (o != fo) e.multi = 1;
                if (prev) e.multi = 1;
                if (k < CTRL) e.ctrl = 1;
            end
            prev = m;
        end
        e.odd = e.multi ? 2'd0 : fo;
        return e;
    endfunction

    task automatic check_diag(input exp_t e, input string tag);
        chk(flt_any == e.any, {tag, " R7 any"}, flt_any, e.any);
        chk(flt_odd == e.odd, {tag, " R6 odd"}, flt_odd, e.odd);
        if (e.any) chk(flt_pos == e.pos, {tag, " R6 pos"}, flt_pos, e.pos);
        chk(flt_multi == e.multi, {tag, " R8 multi"}, flt_multi, e.multi);
        chk(flt_ctrl == e.ctrl, {tag, " R9 ctrl"}, flt_ctrl, e.ctrl);
    endtask

    // Capture with shift also high (R5), optional pause of shift
    task automatic run_scan(input logic [LEN-1:0] a, b, c, input int pause, input string tag);
        int cnt = 0;
        exp_t e = model(a, b, c);
        @(negedge clk);
        ta = a; tb = b; tc = c; capture = 1; shift = 1;
        @(negedge clk);
        capture = 0;
        chk(busy == 1 && flt_any == 0, {tag, " R2 busy after capture"}, busy, 1);
        while (!scan_done && cnt < LEN + pause + 10) begin
            if (cnt == 30) shift = 0;
            if (cnt == 30 + pause) shift = 1;
            @(negedge clk);
            cnt++;
        end
        chk(cnt == LEN + pause, {tag, " R4 R5 R3 done latency"}, cnt, LEN + pause);
        check_diag(e, tag);
        @(negedge clk);
        chk(scan_done == 0 && busy == 0, {tag, " R4 one-cycle pulse"}, scan_done, 0);
    endtask

    function automatic logic [LEN-1:0] rnd_vec();
        logic [LEN-1:0] v;
        for (int k = 0; k < LEN; k++) v[k] = 1'($urandom);
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R4 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [LEN-1:0] a, b, c;
        exp_t e;
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && scan_done == 0, "R1 idle after reset", busy, 0);
        chk(flt_any == 0 && flt_odd == 0 && flt_pos == 0 && flt_ctrl == 0 && flt_multi == 0,
            "R1 diag cleared", flt_any, 0);
        rst_n = 1;
        @(negedge clk);

        // R7 identical taps
        a = rnd_vec();
        run_scan(a, a, a, 0, "clean");
        // R6 single replica, each code, directed first and last index
        b = a; b[0] = ~b[0];
        run_scan(a, b, a, 0, "odd B pos0");
        c = a; c[LEN-1] = ~c[LEN-1];
        run_scan(a, a, c, 0, "odd C last");
        b = a; b[40] = ~b[40]; b[60] = ~b[60];
        run_scan(b, a, a, 0, "odd A two");
        // R8 adjacent positions
        c = a; c[50] = ~c[50]; c[51] = ~c[51];
        run_scan(a, a, c, 0, "adjacent");
        // R8 different replicas
        b = a; c = a; b[20] = ~b[20]; c[70] = ~c[70];
        run_scan(a, b, c, 0, "diff replicas");
        // R9 controller region boundary
        b = a; b[CTRL-1] = ~b[CTRL-1];
        run_scan(a, b, a, 0, "ctrl edge in");
        b = a; b[CTRL] = ~b[CTRL];
        run_scan(a, b, a, 0, "ctrl edge out");
        // R3 pause of shift
        b = a; b[33] = ~b[33];
        run_scan(a, b, a, 5, "pause");

        // R10 shift in IDLE ignored
        e = model(a, b, a);
        shift = 1;
        repeat (6) @(negedge clk);
        chk(busy == 0 && scan_done == 0, "R10 no scan from shift", busy, 0);
        check_diag(e, "R10 idle hold");
        shift = 0;

        // R2 restart mid-scan: first taps dirty, new taps clean except one bit
        c = a; c[5] = ~c[5];
        @(negedge clk);
        ta = a; tb = a; tc = c; capture = 1; shift = 1;
        @(negedge clk);
        capture = 0;
        repeat (20) @(negedge clk);
        b = a; b[90] = ~b[90];
        run_scan(a, b, a, 0, "R2 restart");

        // Random patterns
        for (int n = 0; n < 30; n++) begin
            int mode, r, p;
            logic [LEN-1:0] v[3];
            a = rnd_vec();
            v[0] = a; v[1] = a; v[2] = a;
            mode = $urandom % 5;
            r = $urandom % 3;
            p = $urandom % (LEN - 3);
            case (mode)
                0: ;
                1: v[r][p] = ~v[r][p];
                2: begin v[r][p] = ~v[r][p]; v[r][p+1] = ~v[r][p+1]; end
                3: begin v[r][p] = ~v[r][p]; v[(r+1)%3][p+2] = ~v[(r+1)%3][p+2]; end
                default: v[r][p % CTRL] = ~v[r][p % CTRL];
            endcase
            run_scan(v[0], v[1], v[2], 0, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule